// File: doc/BRIEF.md
# Delta-Panel Scan Timing Generator

This block produces the digital drive waveforms for a small active-matrix LCD panel. The panel has its row and column shift-register drivers built in, and its colour dots sit in a delta pattern. The block runs from one reference clock at twice the horizontal shift-clock rate. Single-cycle horizontal and vertical sync pulses tell it where each line and each frame begin.

For every line, the block emits a start pulse and a complementary pair of horizontal shift clocks. On every other line it delays that whole burst by one reference cycle, which is half a shift-clock period, so that sampling follows the delta offset. When left scan is selected, the two clock phases are swapped.

For the vertical scan, the block emits a start pulse, a shift clock that changes level once per active line, and a gate-enable signal. Gate-enable drops briefly at the start of each active line and stays high at all other times. The block also produces a blanking pulse for the top and bottom bands in wide-aspect mode, a video-polarity flag that flips every line, and registered copies of the scan-direction and standby requests.

Top module: `dpanel_scan_gen`

## Requirements
- R1: While `rst_n` is low, the outputs are: `hstart`=0, `hck_a`=0, `hck_b`=1, `vstart`=0, `vck`=0, `gate_en`=1, `blank`=0, `vid_pol`=0, `dir_h`=1, `dir_v`=1 and `stby_n`=0. After reset, no line or frame is in progress.
- R2: Let t count reference cycles after the edge that captures `hsync`, starting at t=0. Let p be the line parity given by `vid_pol`. Then `hstart` is high exactly at t = HST_OFS+p and t = HST_OFS+p+1, which is one shift-clock period.
- R3: The line phase is 0 before t = S, where S = HST_OFS+p. From t = S to t = S+2·HCLKS it equals (t−S) mod 2, and after that it is 0. This gives exactly HCLKS high pulses per line, each one reference cycle long. `hck_b` is always the complement of `hck_a`.
- R4: On lines with `vid_pol`=1, the whole horizontal burst (`hstart` and the clocks) starts one reference cycle later than on lines with `vid_pol`=0.
- R5: With `scan_right`=1, `hck_a` carries the line phase. With `scan_right`=0, `hck_b` carries it and `hck_a` carries its inverse.
- R6: `vid_pol` inverts at every captured `hsync`. The first line after reset has `vid_pol`=1.
- R7: A `vsync` sets the line count L to 0 and `vck` to 0. Each following `hsync` increments L, saturating at LINES+1. `vck` inverts at each `hsync` that makes L fall in 1..LINES, and holds otherwise.
- R8: `vstart` is high exactly while L ≤ 1. That is, from `vsync` through the end of the first active line, so it spans the first `vck` edge.
- R9: `gate_en` is low only when L is in 1..LINES and t < EN_GAP. It is high at all other times.
- R10: `blank` is high only when `wide_mode`=1, L is in 1..LINES, and L ≤ WIDE_BLK or L > LINES−WIDE_BLK. In 4:3 mode (`wide_mode`=0) it is held low.
- R11: One reference cycle after their inputs change, `dir_h` follows `scan_right`, `dir_v` follows `scan_down`, and `stby_n` is the inverse of `standby`. Low `stby_n` requests power-save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the horizontal shift-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | One-cycle line start pulse |
| vsync | input | 1 | One-cycle frame start pulse |
| scan_right | input | 1 | 1 = right scan, 0 = left scan |
| scan_down | input | 1 | 1 = top-to-bottom scan, 0 = bottom-to-top |
| wide_mode | input | 1 | 1 = 16:9 with band blanking, 0 = 4:3 |
| standby | input | 1 | 1 = request power-save |
| hstart | output | 1 | Horizontal start pulse |
| hck_a | output | 1 | Horizontal shift clock, first phase |
| hck_b | output | 1 | Horizontal shift clock, second phase |
| vstart | output | 1 | Vertical start pulse |
| vck | output | 1 | Vertical shift clock |
| gate_en | output | 1 | Gate-line enable |
| blank | output | 1 | Top/bottom band blanking pulse |
| vid_pol | output | 1 | Per-line video polarity / line parity |
| dir_h | output | 1 | Registered horizontal direction |
| dir_v | output | 1 | Registered vertical direction |
| stby_n | output | 1 | Registered standby, low = power-save |

## Verification
The assertions check the following on every cycle:
- `hstart` lasts exactly two cycles, and the phase toggles throughout it.
- `vid_pol` flips at each line start.
- `vsync` clears the vertical state.
- `vstart`, `blank` and a low `gate_en` appear only within their allowed line or cycle windows.

Other properties can only be shown by the scenarios:
- the exact position of the burst and its one-cycle delay on alternate lines;
- the count of HCLKS pulses per line;
- the phase swap under left scan;
- the line-by-line `vck` levels and the band edges of `blank` for each mode combination.

// File: rtl/dpanel_scan_gen.sv
module dpanel_scan_gen #(
  parameter int LINES    = 225,
  parameter int HCLKS    = 267,
  parameter int HST_OFS  = 4,
  parameter int EN_GAP   = 8,
  parameter int WIDE_BLK = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  input  logic scan_right,
  input  logic scan_down,
  input  logic wide_mode,
  input  logic standby,
  output logic hstart,
  output logic hck_a,
  output logic hck_b,
  output logic vstart,
  output logic vck,
  output logic gate_en,
  output logic blank,
  output logic vid_pol,
  output logic dir_h,
  output logic dir_v,
  output logic stby_n
);
  localparam int TLIM = HST_OFS + 2*HCLKS + 2;
  localparam int TW   = $clog2(TLIM + 2) + 1;
  localparam int VW   = $clog2(LINES + 2) + 1;
  localparam logic [TW-1:0] T_MAX  = TW'(TLIM);
  localparam logic [TW-1:0] T_RUN  = TW'(2*HCLKS);
  localparam logic [TW-1:0] T_OFS  = TW'(HST_OFS);
  localparam logic [TW-1:0] T_GAP  = TW'(EN_GAP);
  localparam logic [VW-1:0] V_LAST = VW'(LINES);
  localparam logic [VW-1:0] V_IDLE = VW'(LINES + 1);
  localparam logic [VW-1:0] V_TOPB = VW'(WIDE_BLK);
  localparam logic [VW-1:0] V_BOTB = VW'(LINES - WIDE_BLK);

  logic [TW-1:0] t_q, t_n, st_n;
  logic [VW-1:0] vcnt_q, vcnt_n;
  logic odd_q, odd_n, ph_q, ph_n, in_win, act_n, vck_n;

  assign odd_n  = hsync ? ~odd_q : odd_q;
  assign t_n    = hsync ? '0 : (t_q == T_MAX) ? t_q : t_q + 1'b1;
  assign st_n   = T_OFS + {{(TW-1){1'b0}}, odd_n};
  assign in_win = (t_n >= st_n) && (t_n <= st_n + T_RUN);
  assign ph_n   = in_win & (t_n[0] ^ st_n[0]);

  assign vcnt_n = vsync ? '0 :
                  (hsync && vcnt_q != V_IDLE) ? vcnt_q + 1'b1 : vcnt_q;
  assign act_n  = (vcnt_n != '0) && (vcnt_n <= V_LAST);
  assign vck_n  = vsync ? 1'b0 : (hsync && act_n) ? ~vck_q : vck_q;

  logic vck_q;
  assign vck = vck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q     <= T_MAX;
      odd_q   <= 1'b0;
      ph_q    <= 1'b0;
      vcnt_q  <= V_IDLE;
      vck_q   <= 1'b0;
      hstart  <= 1'b0;
      hck_a   <= 1'b0;
      hck_b   <= 1'b1;
      vstart  <= 1'b0;
      gate_en <= 1'b1;
      blank   <= 1'b0;
      vid_pol <= 1'b0;
      dir_h   <= 1'b1;
      dir_v   <= 1'b1;
      stby_n  <= 1'b0;
    end else begin
      t_q     <= t_n;
      odd_q   <= odd_n;
      ph_q    <= ph_n;
      vcnt_q  <= vcnt_n;
      vck_q   <= vck_n;
      hstart  <= (t_n == st_n) || (t_n == st_n + 1'b1);
      hck_a   <= scan_right ? ph_n : ~ph_n;
      hck_b   <= scan_right ? ~ph_n : ph_n;
      vstart  <= (vcnt_n <= VW'(1));
      gate_en <= ~(act_n && (t_n < T_GAP));
      blank   <= wide_mode && act_n && ((vcnt_n <= V_TOPB) || (vcnt_n > V_BOTB));
      vid_pol <= odd_n;
      dir_h   <= scan_right;
      dir_v   <= scan_down;
      stby_n  <= ~standby;
    end
  end

  a_r2_hstart_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hstart) && !hsync |=> hstart);
  a_r2_hstart_ends: assert property (@(posedge clk) disable iff (!rst_n)
    hstart && $past(hstart) && !hsync |=> !hstart);
  a_r3_phase_runs: assert property (@(posedge clk) disable iff (!rst_n)
    hstart && !hsync |=> ph_q != $past(ph_q));
  a_r6_pol_flips: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> vid_pol != $past(vid_pol));
  a_r7_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (vcnt_q == '0) && !vck);
  a_r8_vstart_window: assert property (@(posedge clk) disable iff (!rst_n)
    vstart |-> vcnt_q <= VW'(1));
  a_r9_gate_window: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> t_q < T_GAP);
  a_r10_blank_active: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (vcnt_q != '0) && (vcnt_q <= V_LAST));
endmodule

// File: tb/tb_dpanel_scan_gen.sv
module tb_dpanel_scan_gen;
  localparam int LINES = 6, HCLKS = 4, HST_OFS = 2, EN_GAP = 3, WIDE_BLK = 1;
  localparam int LLEN = 16;
  // {scan_right, scan_down, wide_mode, standby, exp dir_h, exp dir_v, exp stby_n}
  localparam logic [6:0] VEC [4] = '{7'b1100_111, 7'b0110_011, 7'b1011_100, 7'b0001_000};

  logic clk = 0, rst_n = 0, hsync = 0, vsync = 0;
  logic scan_right = 1, scan_down = 1, wide_mode = 0, standby = 0;
  logic hstart, hck_a, hck_b, vstart, vck, gate_en, blank, vid_pol, dir_h, dir_v, stby_n;
  int nvec = 0, nfail = 0;
  logic par = 0, evck = 0;

  dpanel_scan_gen #(.LINES(LINES), .HCLKS(HCLKS), .HST_OFS(HST_OFS),
                    .EN_GAP(EN_GAP), .WIDE_BLK(WIDE_BLK)) dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .scan_right(scan_right), .scan_down(scan_down), .wide_mode(wide_mode),
    .standby(standby), .hstart(hstart), .hck_a(hck_a), .hck_b(hck_b),
    .vstart(vstart), .vck(vck), .gate_en(gate_en), .blank(blank),
    .vid_pol(vid_pol), .dir_h(dir_h), .dir_v(dir_v), .stby_n(stby_n));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_reset();
    chk("R1 hstart", hstart, 0);   chk("R1 hck_a", hck_a, 0);
    chk("R1 hck_b", hck_b, 1);     chk("R1 vstart", vstart, 0);
    chk("R1 vck", vck, 0);         chk("R1 gate_en", gate_en, 1);
    chk("R1 blank", blank, 0);     chk("R1 vid_pol", vid_pol, 0);
    chk("R1 dir_h", dir_h, 1);     chk("R1 dir_v", dir_v, 1);
    chk("R1 stby_n", stby_n, 0);
  endtask

  task automatic frame_start();
    vsync = 1;
    @(negedge clk);
    vsync = 0;
    evck = 0;
    chk("R8 vstart at frame", vstart, 1);
    chk("R7 vck cleared", vck, 0);
    chk("R9 gate_en idle", gate_en, 1);
    chk("R10 blank idle", blank, 0);
    @(negedge clk);
  endtask

  task automatic run_line(input int L);
    int s, ph, ea, rises, prev, lc, inact, eb;
    hsync = 1;
    @(negedge clk);
    hsync = 0;
    par = ~par;
    lc = (L > LINES + 1) ? LINES + 1 : L;
    inact = (lc >= 1 && lc <= LINES);
    if (inact) evck = ~evck;
    s = HST_OFS + par;
    rises = 0; prev = 0;
    for (int t = 0; t < LLEN; t++) begin
      if (t > 0) @(negedge clk);
      ph = (t >= s && t <= s + 2*HCLKS) ? ((t - s) % 2) : 0;
      ea = scan_right ? ph : 1 - ph;
      chk(par ? "R4 hstart odd line" : "R2 hstart", hstart, (t == s || t == s + 1));
      chk(scan_right ? "R3 hck_a" : "R5 hck_a swapped", hck_a, ea);
      chk("R3 hck_b", hck_b, 1 - ea);
      chk("R6 vid_pol", vid_pol, par);
      chk("R7 vck", vck, evck);
      chk("R8 vstart", vstart, lc <= 1);
      chk("R9 gate_en", gate_en, !(inact && t < EN_GAP));
      eb = wide_mode && inact && (lc <= WIDE_BLK || lc > LINES - WIDE_BLK);
      chk("R10 blank", blank, eb);
      if ((scan_right ? hck_a : hck_b) && !prev) rises++;
      prev = scan_right ? hck_a : hck_b;
    end
    chk("R3 pulse count", rises, HCLKS);
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset();
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      {scan_right, scan_down, wide_mode, standby} = VEC[i][6:3];
      @(negedge clk);
      @(negedge clk);
      chk("R11 dir_h", dir_h, VEC[i][2]);
      chk("R11 dir_v", dir_v, VEC[i][1]);
      chk("R11 stby_n", stby_n, VEC[i][0]);
      frame_start();
      for (int L = 1; L <= LINES + 2; L++) run_line(L);
    end
    // reset mid-line, then confirm parity restarts at 1
    scan_right = 1; wide_mode = 1; standby = 0;
    frame_start();
    run_line(1);
    hsync = 1;
    @(negedge clk);
    hsync = 0;
    rst_n = 0;
    @(negedge clk);
    chk_reset();
    rst_n = 1;
    par = 0;
    evck = 0;
    @(negedge clk);
    frame_start();
    for (int L = 1; L <= 3; L++) run_line(L);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule